// File: doc/BRIEF.md
# Stack and Call/Return Sequencer

This block owns the program counter and the stack pointer of a small 8-bit controller core. It takes one control-transfer or stack command at a time from the instruction decoder. The command set covers long and page-relative calls, returns (plain and interrupt), pushes and pops of a directly addressed byte, long, page-relative and short jumps, and four conditional relative branches. The command arrives with one 16-bit operand field. Depending on the command, that field holds a full target, an 11-bit in-page target, a signed 8-bit displacement or an 8-bit direct address.

Stack traffic goes through a byte-wide port to the internal data RAM, with at most one access per cycle. A read returns its data in the cycle after the request. The stack grows upward. A push pre-increments the pointer and writes. A pop reads and then post-decrements. A 16-bit return address goes onto the stack low byte first and comes off high byte first. Multi-cycle commands hold `busy` high until the last stack byte has moved. Every command then signals completion with a one-cycle `done`. A new command may be presented in the same cycle as that `done`.

Top module: `call_return_seq`

## Requirements
- R1: After reset, `pc` is 0000h, `sp` is 07h, and `busy`, `done` and `intDone` are all low.
- R2: Long call (op 0). The PC first advances by 3. That value goes to RAM at SP+1 (low byte), then at SP+2 (high byte), one byte per cycle. SP ends 2 higher and the PC loads the full 16-bit operand. `busy` is high for 2 cycles.
- R3: Page call (op 1). The PC advances by 2 and is pushed as in R2. The PC then takes operand bits [10:0] and keeps bits [15:11] of the advanced PC.
- R4: Return (op 2). PC[15:8] is read from RAM at SP and SP is decremented. PC[7:0] is then read from RAM at the new SP and SP is decremented again. `busy` is high for 3 cycles.
- R5: Interrupt return (op 3) does exactly what R4 does. It also raises `intDone` for the single cycle in which `done` is high.
- R6: Push (op 4). The byte at direct address operand[7:0] is read, SP is incremented, and the byte is written at the new SP. The PC advances by 2 and `busy` is high for 2 cycles.
- R7: Pop (op 5). The byte at SP is read and SP is decremented. The byte is then written to direct address operand[7:0]. The PC advances by 2 and `busy` is high for 2 cycles.
- R8: Long jump (op 6) loads the operand into the PC. Page jump (op 7) replaces bits [10:0] of PC+2 with operand[10:0]. Both complete with `done` in the next cycle and never raise `busy`.
- R9: Short jump (op 8) sets PC to PC+2 plus operand[7:0] read as a signed value (−128..+127).
- R10: Conditional branches use op 9 (carry set), op 10 (carry clear), op 11 (`accIn` zero) and op 12 (`accIn` non-zero). Each sets PC to PC+2, plus the signed displacement only when its condition holds.
- R11: SP increments and decrements wrap modulo 256, and SP moves by at most one per cycle.
- R12: `busy` rises in the cycle after a multi-cycle command is accepted and stays high until the last stack byte has been transferred. `done` pulses one cycle after completion, while `busy` is low. RAM requests occur only while `busy` is high.
- R13: `ramRe` and `ramWe` are never high in the same cycle.
- R14: A command presented while `busy` is high is ignored, and so is an op code of 13 to 15. Neither changes `pc` or `sp` or produces `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 4 | Command code (0..12) |
| cmdArg | input | 16 | Operand: target, page field, displacement or direct address |
| carryIn | input | 1 | Carry flag for conditional branches |
| accIn | input | 8 | Accumulator value for zero tests |
| ramRe | output | 1 | RAM read request |
| ramWe | output | 1 | RAM write request |
| ramAddr | output | 8 | RAM byte address |
| ramWdata | output | 8 | RAM write data |
| ramRdata | input | 8 | RAM read data, valid the cycle after `ramRe` |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Stack transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| intDone | output | 1 | One-cycle pulse on completing an interrupt return |

## Verification
The completion of one command and the acceptance of the next can fall in the same cycle. Every command after the first is presented in the cycle where the previous one shows `done`, so the run is a chain of commands with no gap between them. Each one is judged against a behavioural model of PC, SP and stack memory, and it must still produce its own busy length and final state. A second overlap is a command offered during the first busy cycle of a call. The bench checks that the call still ends at its own target, and that the offered command leaves no later trace.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int PC_W   = 16;
  localparam int SP_W   = 8;
  localparam int DATA_W = 8;
  localparam int PAGE_W = 11;
  localparam int REL_W  = 8;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LCALL = 4'd0,
    OP_ACALL = 4'd1,
    OP_RET   = 4'd2,
    OP_RETI  = 4'd3,
    OP_PUSH  = 4'd4,
    OP_POP   = 4'd5,
    OP_LJMP  = 4'd6,
    OP_AJMP  = 4'd7,
    OP_SJMP  = 4'd8,
    OP_JC    = 4'd9,
    OP_JNC   = 4'd10,
    OP_JZ    = 4'd11,
    OP_JNZ   = 4'd12
  } op_e;

  typedef enum logic [3:0] {
    PC_HOLD, PC_ADV2, PC_ADV3, PC_ABS, PC_PAGE_ADV, PC_PAGE, PC_REL, PC_HI, PC_LO
  } pcSel_e;

  typedef enum logic [1:0] { SP_HOLD, SP_INC, SP_DEC } spOp_e;

  typedef enum logic [1:0] { RA_SPNEXT, RA_SP, RA_ARG } addrSel_e;

  typedef enum logic [1:0] { WD_PCLO, WD_PCHI, WD_RDATA } wdSel_e;

  typedef struct packed {
    pcSel_e   pcSel;
    spOp_e    spOp;
    logic     argLoad;
    logic     ramRe;
    logic     ramWe;
    addrSel_e addrSel;
    wdSel_e   wdSel;
  } strobe_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [OP_W-1:0] cmdOp,
  input  logic            carryIn,
  input  logic [DATA_W-1:0] accIn,
  output strobe_t         st,
  output logic            busy,
  output logic            done,
  output logic            intDone
);
  typedef enum logic [3:0] {
    S_IDLE, S_CALL_LO, S_CALL_HI, S_RET_A, S_RET_B, S_RET_C,
    S_PUSH_RD, S_PUSH_WR, S_POP_RD, S_POP_WR
  } state_e;

  state_e          stateQ, stateD;
  logic [OP_W-1:0] opQ;
  logic            doneQ, intQ;
  logic            fin, finInt;
  logic            accZero;

  assign accZero = (accIn == '0);

  always_comb begin
    stateD     = stateQ;
    fin        = 1'b0;
    finInt     = 1'b0;
    st         = '0;
    st.pcSel   = PC_HOLD;
    st.spOp    = SP_HOLD;
    st.addrSel = RA_SP;
    st.wdSel   = WD_RDATA;
    unique case (stateQ)
      S_IDLE: begin
        if (cmdValid) begin
          st.argLoad = 1'b1;
          case (cmdOp)
            OP_LCALL: begin st.pcSel = PC_ADV3; stateD = S_CALL_LO; end
            OP_ACALL: begin st.pcSel = PC_ADV2; stateD = S_CALL_LO; end
            OP_RET,
            OP_RETI:  stateD = S_RET_A;
            OP_PUSH:  begin st.pcSel = PC_ADV2; stateD = S_PUSH_RD; end
            OP_POP:   begin st.pcSel = PC_ADV2; stateD = S_POP_RD; end
            OP_LJMP:  begin st.pcSel = PC_ABS; fin = 1'b1; end
            OP_AJMP:  begin st.pcSel = PC_PAGE_ADV; fin = 1'b1; end
            OP_SJMP:  begin st.pcSel = PC_REL; fin = 1'b1; end
            OP_JC:    begin st.pcSel = carryIn  ? PC_REL : PC_ADV2; fin = 1'b1; end
            OP_JNC:   begin st.pcSel = !carryIn ? PC_REL : PC_ADV2; fin = 1'b1; end
            OP_JZ:    begin st.pcSel = accZero  ? PC_REL : PC_ADV2; fin = 1'b1; end
            OP_JNZ:   begin st.pcSel = !accZero ? PC_REL : PC_ADV2; fin = 1'b1; end
            default:  st.argLoad = 1'b0;
          endcase
        end
      end
      S_CALL_LO: begin
        st.ramWe = 1'b1; st.addrSel = RA_SPNEXT; st.wdSel = WD_PCLO;
        st.spOp = SP_INC; stateD = S_CALL_HI;
      end
      S_CALL_HI: begin
        st.ramWe = 1'b1; st.addrSel = RA_SPNEXT; st.wdSel = WD_PCHI;
        st.spOp = SP_INC;
        st.pcSel = (opQ == OP_LCALL) ? PC_ABS : PC_PAGE;
        fin = 1'b1; stateD = S_IDLE;
      end
      S_RET_A: begin
        st.ramRe = 1'b1; st.addrSel = RA_SP; st.spOp = SP_DEC; stateD = S_RET_B;
      end
      S_RET_B: begin
        st.ramRe = 1'b1; st.addrSel = RA_SP; st.spOp = SP_DEC;
        st.pcSel = PC_HI; stateD = S_RET_C;
      end
      S_RET_C: begin
        st.pcSel = PC_LO; fin = 1'b1; finInt = (opQ == OP_RETI);
        stateD = S_IDLE;
      end
      S_PUSH_RD: begin
        st.ramRe = 1'b1; st.addrSel = RA_ARG; stateD = S_PUSH_WR;
      end
      S_PUSH_WR: begin
        st.ramWe = 1'b1; st.addrSel = RA_SPNEXT; st.wdSel = WD_RDATA;
        st.spOp = SP_INC; fin = 1'b1; stateD = S_IDLE;
      end
      S_POP_RD: begin
        st.ramRe = 1'b1; st.addrSel = RA_SP; st.spOp = SP_DEC; stateD = S_POP_WR;
      end
      S_POP_WR: begin
        st.ramWe = 1'b1; st.addrSel = RA_ARG; st.wdSel = WD_RDATA;
        fin = 1'b1; stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      opQ    <= '0;
      doneQ  <= 1'b0;
      intQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= fin;
      intQ   <= finInt;
      if (stateQ == S_IDLE && cmdValid) opQ <= cmdOp;
    end
  end

  assign busy    = (stateQ != S_IDLE);
  assign done    = doneQ;
  assign intDone = intQ;
endmodule

// File: rtl/seq_dp.sv
module seq_dp
  import seq_pkg::*;
#(
  parameter logic [PC_W-1:0] PC_RESET = '0,
  parameter logic [SP_W-1:0] SP_RESET = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [PC_W-1:0]   cmdArg,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [SP_W-1:0]   ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  output logic [PC_W-1:0]   pc,
  output logic [SP_W-1:0]   sp
);
  localparam int HI_LSB = PC_W - DATA_W;

  logic [PC_W-1:0] pcQ, pcD, argQ, opnd, pcAdv2, pcAdv3, relExt;
  logic [SP_W-1:0] spQ, spD, spNext;

  assign opnd   = st.argLoad ? cmdArg : argQ;
  assign pcAdv2 = pcQ + PC_W'(2);
  assign pcAdv3 = pcQ + PC_W'(3);
  assign relExt = {{(PC_W-REL_W){opnd[REL_W-1]}}, opnd[REL_W-1:0]};
  assign spNext = spQ + SP_W'(1);

  always_comb begin
    unique case (st.pcSel)
      PC_ADV2:     pcD = pcAdv2;
      PC_ADV3:     pcD = pcAdv3;
      PC_ABS:      pcD = opnd;
      PC_PAGE_ADV: pcD = {pcAdv2[PC_W-1:PAGE_W], opnd[PAGE_W-1:0]};
      PC_PAGE:     pcD = {pcQ[PC_W-1:PAGE_W], opnd[PAGE_W-1:0]};
      PC_REL:      pcD = pcAdv2 + relExt;
      PC_HI:       pcD = {ramRdata, pcQ[HI_LSB-1:0]};
      PC_LO:       pcD = {pcQ[PC_W-1:DATA_W], ramRdata};
      default:     pcD = pcQ;
    endcase
  end

  always_comb begin
    unique case (st.spOp)
      SP_INC:  spD = spNext;
      SP_DEC:  spD = spQ - SP_W'(1);
      default: spD = spQ;
    endcase
  end

  always_comb begin
    unique case (st.addrSel)
      RA_SPNEXT: ramAddr = spNext;
      RA_ARG:    ramAddr = opnd[SP_W-1:0];
      default:   ramAddr = spQ;
    endcase
  end

  always_comb begin
    unique case (st.wdSel)
      WD_PCLO: ramWdata = pcQ[DATA_W-1:0];
      WD_PCHI: ramWdata = pcQ[PC_W-1:HI_LSB];
      default: ramWdata = ramRdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ  <= PC_RESET;
      spQ  <= SP_RESET;
      argQ <= '0;
    end else begin
      pcQ <= pcD;
      spQ <= spD;
      if (st.argLoad) argQ <= cmdArg;
    end
  end

  assign pc = pcQ;
  assign sp = spQ;
endmodule

// File: rtl/call_return_seq.sv
module call_return_seq
  import seq_pkg::*;
#(
  parameter logic [PC_W-1:0] PC_RESET = '0,
  parameter logic [SP_W-1:0] SP_RESET = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [OP_W-1:0]   cmdOp,
  input  logic [PC_W-1:0]   cmdArg,
  input  logic              carryIn,
  input  logic [DATA_W-1:0] accIn,
  output logic              ramRe,
  output logic              ramWe,
  output logic [SP_W-1:0]   ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [PC_W-1:0]   pc,
  output logic [SP_W-1:0]   sp,
  output logic              busy,
  output logic              done,
  output logic              intDone
);
  strobe_t st;

  seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .carryIn(carryIn), .accIn(accIn), .st(st),
    .busy(busy), .done(done), .intDone(intDone)
  );

  seq_dp #(.PC_RESET(PC_RESET), .SP_RESET(SP_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .cmdArg(cmdArg), .ramRdata(ramRdata),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .pc(pc), .sp(sp)
  );

  assign ramRe = st.ramRe;
  assign ramWe = st.ramWe;
endmodule

// File: rtl/call_return_seq_chk.sv
module call_return_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic        ramRe,
  input logic        ramWe,
  input logic [15:0] pc,
  input logic [7:0]  sp,
  input logic        busy,
  input logic        done,
  input logic        intDone
);
  a_r13_single_access: assert property (@(posedge clk) disable iff (!rstN)
    !(ramRe && ramWe));

  a_r12_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r12_ram_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    (ramRe || ramWe) |-> busy);

  a_r5_int_with_done: assert property (@(posedge clk) disable iff (!rstN)
    intDone |-> done);

  a_r14_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cmdValid) |=> ($stable(pc) && $stable(sp) && !busy && !done));

  a_r11_sp_unit_step: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (sp == $past(sp) || sp == $past(sp) + 8'd1 || sp == $past(sp) - 8'd1));
endmodule

bind call_return_seq call_return_seq_chk u_chk (.*);

// File: tb/call_return_seq_tb.sv
`timescale 1ns/1ps
module call_return_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [3:0]  cmdOp = '0;
  logic [15:0] cmdArg = '0;
  logic        carryIn = 1'b0;
  logic [7:0]  accIn = '0;
  logic        ramRe, ramWe, busy, done, intDone;
  logic [7:0]  ramAddr, ramWdata, sp;
  logic [7:0]  ramRdata;
  logic [15:0] pc;

  logic [7:0]  mem [256];
  logic [7:0]  refMem [256];
  logic [15:0] mPc;
  logic [7:0]  mSp;
  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  call_return_seq u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdArg(cmdArg),
    .carryIn(carryIn), .accIn(accIn), .ramRe(ramRe), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .ramRdata(ramRdata),
    .pc(pc), .sp(sp), .busy(busy), .done(done), .intDone(intDone)
  );

  // Bench RAM: one-cycle read latency, initial pattern loaded during reset
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
      ramRdata <= '0;
    end else begin
      if (ramWe) mem[ramAddr] <= ramWdata;
      if (ramRe) ramRdata <= mem[ramAddr];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R13: never a read and a write together, judged every cycle
  always @(negedge clk) begin
    if (rstN && !finished)
      chk(!(ramRe && ramWe), "R13", "read and write together", {ramRe, ramWe}, 0);
  end

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4: return "R6";
      4'd5: return "R7";
      4'd6, 4'd7: return "R8";
      4'd8: return "R9";
      4'd9, 4'd10, 4'd11, 4'd12: return "R10";
      default: return "R14";
    endcase
  endfunction

  function automatic logic [15:0] sext(input logic [7:0] v);
    return {{8{v[7]}}, v};
  endfunction

  task automatic mPush(input logic [7:0] d);
    mSp = mSp + 8'd1;
    refMem[mSp] = d;
  endtask

  task automatic doCmd(input logic [3:0] op, input logic [15:0] arg,
                       input logic c, input logic [7:0] acc, input bit poke);
    int nb;
    bit expDone, expInt, take;
    logic [15:0] ret;
    logic [7:0] hi, lo, d;
    int bad;
    string rq;
    rq = reqOf(op);
    nb = 0; expDone = 1; expInt = 0; take = 0;
    case (op)
      4'd0: begin ret = mPc + 16'd3; mPush(ret[7:0]); mPush(ret[15:8]); mPc = arg; nb = 2; end
      4'd1: begin ret = mPc + 16'd2; mPush(ret[7:0]); mPush(ret[15:8]);
                  mPc = {ret[15:11], arg[10:0]}; nb = 2; end
      4'd2, 4'd3: begin hi = refMem[mSp]; mSp = mSp - 8'd1; lo = refMem[mSp];
                  mSp = mSp - 8'd1; mPc = {hi, lo}; nb = 3; expInt = (op == 4'd3); end
      4'd4: begin d = refMem[arg[7:0]]; mPush(d); mPc = mPc + 16'd2; nb = 2; end
      4'd5: begin d = refMem[mSp]; mSp = mSp - 8'd1; refMem[arg[7:0]] = d;
                  mPc = mPc + 16'd2; nb = 2; end
      4'd6: mPc = arg;
      4'd7: begin ret = mPc + 16'd2; mPc = {ret[15:11], arg[10:0]}; end
      4'd8: mPc = mPc + 16'd2 + sext(arg[7:0]);
      4'd9, 4'd10, 4'd11, 4'd12: begin
        case (op)
          4'd9:  take = c;
          4'd10: take = !c;
          4'd11: take = (acc == 8'd0);
          default: take = (acc != 8'd0);
        endcase
        mPc = mPc + 16'd2 + (take ? sext(arg[7:0]) : 16'd0);
      end
      default: expDone = 0;
    endcase
    cmdValid = 1'b1; cmdOp = op; cmdArg = arg; carryIn = c; accIn = acc;
    @(negedge clk);
    if (poke) begin cmdValid = 1'b1; cmdOp = 4'd6; cmdArg = 16'hDEAD; end
    else cmdValid = 1'b0;
    for (int i = 0; i < nb; i++) begin
      chk(busy === 1'b1, "R12", {rq, " busy during transfer"}, busy, 1);
      chk(done === 1'b0, "R12", {rq, " no done while busy"}, done, 0);
      @(negedge clk);
      cmdValid = 1'b0;
    end
    chk(busy === 1'b0, "R12", {rq, " busy released"}, busy, 0);
    chk(done === expDone, expDone ? "R12" : "R14", {rq, " done pulse"}, done, expDone);
    chk(intDone === expInt, "R5", {rq, " intDone"}, intDone, expInt);
    chk(pc === mPc, rq, "pc", pc, mPc);
    chk(sp === mSp, rq, "sp", sp, mSp);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== refMem[i]) bad++;
    chk(bad == 0, rq, "stack memory mismatches", bad, 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) refMem[i] = 8'(i * 7 + 3);
    mPc = 16'h0000;
    mSp = 8'h07;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pc === 16'h0000, "R1", "pc after reset", pc, 0);
    chk(sp === 8'h07, "R1", "sp after reset", sp, 7);
    chk(busy === 1'b0 && done === 1'b0 && intDone === 1'b0, "R1", "flags after reset",
        {busy, done, intDone}, 0);

    // Chain: each command presented in the done cycle of the previous one
    doCmd(4'd6, 16'h1200, 0, 8'h00, 0);   // R8 long jump
    doCmd(4'd0, 16'h3456, 0, 8'h00, 0);   // R2 long call
    doCmd(4'd1, 16'h07FE, 0, 8'h00, 0);   // R3 page call
    doCmd(4'd6, 16'h37FE, 0, 8'h00, 0);   // R8
    doCmd(4'd7, 16'h0123, 0, 8'h00, 0);   // R8 page jump across page edge
    doCmd(4'd8, 16'h00FE, 0, 8'h00, 0);   // R9 -2
    doCmd(4'd8, 16'h007F, 0, 8'h00, 0);   // R9 +127
    doCmd(4'd8, 16'h0080, 0, 8'h00, 0);   // R9 -128
    doCmd(4'd9, 16'h0010, 1, 8'h00, 0);   // R10 carry set taken
    doCmd(4'd9, 16'h0010, 0, 8'h00, 0);   // R10 not taken
    doCmd(4'd10, 16'h00F0, 0, 8'h00, 0);  // R10 carry clear taken
    doCmd(4'd11, 16'h0020, 0, 8'h00, 0);  // R10 zero taken
    doCmd(4'd11, 16'h0020, 0, 8'h01, 0);  // R10 zero not taken
    doCmd(4'd12, 16'h0030, 0, 8'h80, 0);  // R10 non-zero taken
    doCmd(4'd12, 16'h0030, 0, 8'h00, 0);  // R10 non-zero not taken
    doCmd(4'd4, 16'h00E0, 0, 8'h00, 0);   // R6 push
    doCmd(4'd5, 16'h0030, 0, 8'h00, 0);   // R7 pop
    doCmd(4'd3, 16'h0000, 0, 8'h00, 0);   // R5 interrupt return
    doCmd(4'd2, 16'h0000, 0, 8'h00, 0);   // R4 return
    doCmd(4'd13, 16'h5555, 0, 8'h00, 0);  // R14 undefined op
    doCmd(4'd15, 16'h5555, 1, 8'h00, 0);  // R14 undefined op
    doCmd(4'd0, 16'hABCD, 0, 8'h00, 1);   // R14 stray command while busy
    doCmd(4'd2, 16'h0000, 0, 8'h00, 0);   // R4
    // R11: pop down through zero, then push across the wrap
    while (mSp != 8'hFF) doCmd(4'd5, 16'h0040, 0, 8'h00, 0);
    chk(sp === 8'hFF, "R11", "sp wrapped down", sp, 8'hFF);
    doCmd(4'd4, 16'h0041, 0, 8'h00, 0);
    chk(sp === 8'h00, "R11", "sp wrapped up", sp, 0);
    doCmd(4'd0, 16'h4000, 0, 8'h00, 0);   // R2 call from wrapped pointer
    doCmd(4'd2, 16'h0000, 0, 8'h00, 0);   // R4
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule